// File: doc/BRIEF.md
# Transfer Byte Counter with Status

This block keeps the remaining byte count of a counted data transfer and reports on it in a one-byte status word. The host programs a 24-bit start count through three byte-wide staging registers. Nothing moves into the counter until the command decoder accepts a command whose "use DMA" flag is set. At that point the counter takes the staged value.

After a load, every pulse on the byte strobe takes one byte off the count. The counter never passes through zero. Two flags come out of it: one says the count is zero, and the other says a counted transfer has finished. Both appear in the status byte. The status byte also carries the current bus phase and two error flags, all of which come from outside the block.

Reads of the three count indices return the live remaining count, not the staged value. The block holds no copy of the original load value.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset, all three count bytes read 0, the zero flag is 1, the done flag is 0, and status bits 4:3 are `10`.
- R2: A write to index 0, 1 or 0xE places its data in the low, middle or high staging byte. A write does not change the live count.
- R3: An accepted command with bit 7 set loads the count from the staging registers, and the new count is readable on the next cycle. An accepted command with bit 7 clear leaves both the count and the flags unchanged.
- R4: Each cycle with the byte strobe high and a nonzero count lowers the count by exactly one.
- R5: A byte strobe that arrives while the count is zero is ignored. The count stays at zero and does not wrap.
- R6: Reading index 0, 1 or 0xE returns bits 7:0, 15:8 or 23:16 of the live count. Every other index reads 0.
- R7: The zero flag and status bit 4 are 1 exactly when the live count is zero.
- R8: The done flag (status bit 3) sets in either of two cases: a strobe takes the count from 1 to 0, or a load brings in zero. Its value appears one cycle later. A load of a nonzero value clears it. In all other cases it holds its value.
- R9: Status bits 2:0 repeat the bus-phase input. The phase code is MSG, C/D, I/O: 000 data-out, 001 data-in, 010 command, 011 status, 110 message-out, 111 message-in. Bit 5 repeats the parity-error input, bit 6 repeats the gross-error input, and bit 7 reads 0.
- R10: When a load and a byte strobe occur in the same cycle, the load wins and that strobe is dropped.
- R11: A load uses the staging value from before any register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 8 | Live count byte at rd_idx, 0 for other indices |
| cmd_valid | input | 1 | Command accepted by the decoder this cycle |
| cmd_byte | input | 8 | Accepted command byte; bit 7 requests a counted transfer |
| byte_stb | input | 1 | One byte moved this cycle |
| bus_phase | input | 3 | Current bus phase (MSG, C/D, I/O) |
| parity_err | input | 1 | Parity error indication |
| gross_err | input | 1 | Gross error indication |
| status | output | 8 | Status byte |
| cnt_zero | output | 1 | Live count is zero |
| xfer_done | output | 1 | Counted transfer has completed |

## Verification
A wrong count shows up at rd_data and at the zero flag on the cycle after the bad strobe or load. Any wrap past zero shows as a count of 0xFFFFFF on the next read. A done flag that sets on the wrong edge, or fails to clear, shows in status bit 3 one cycle after the event that should have changed it. Bad staging shows only at the next load, so the bench reads the count right after each load and again after same-cycle write/load and strobe/load collisions.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned DMA_BIT  = 7;
  localparam int unsigned ST_DONE  = 3;
  localparam int unsigned ST_ZERO  = 4;
  localparam int unsigned ST_PAR   = 5;
  localparam int unsigned ST_GROSS = 6;

  typedef enum logic [2:0] {
    PH_DATA_OUT = 3'b000,
    PH_DATA_IN  = 3'b001,
    PH_COMMAND  = 3'b010,
    PH_STATUS   = 3'b011,
    PH_MSG_OUT  = 3'b110,
    PH_MSG_IN   = 3'b111
  } bus_phase_e;
endpackage

// File: rtl/xbc_stage_regs.sv
module xbc_stage_regs #(
  parameter int unsigned BYTES = 3,
  parameter int unsigned IDX_W = 4,
  parameter logic [BYTES*IDX_W-1:0] IDX_MAP = {4'hE, 4'h1, 4'h0}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  output logic [BYTES*8-1:0]     stage
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic       hit;
    logic [7:0] byte_d;
    logic [7:0] byte_q;

    always_comb begin
      hit    = wr_en && (wr_idx == IDX_MAP[b*IDX_W +: IDX_W]);
      byte_d = hit ? wr_data : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else if (hit) byte_q <= byte_d;
    end

    assign stage[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/xbc_down_counter.sv
module xbc_down_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_stb,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             done_q, done_d;
  logic             cnt_en;
  logic             at_zero, at_one;

  always_comb begin
    at_zero = (count_q == '0);
    at_one  = (count_q == CNT_W'(1));
    count_d = count_q;
    done_d  = done_q;
    if (load) begin
      count_d = load_val;
      done_d  = (load_val == '0);
    end else if (dec_stb && !at_zero) begin
      count_d = count_q - CNT_W'(1);
      if (at_one) done_d = 1'b1;
    end
    cnt_en = load || (dec_stb && !at_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (cnt_en) begin
      count_q <= count_d;
      done_q  <= done_d;
    end
  end

  assign count = count_q;
  assign done  = done_q;
endmodule

// File: rtl/xbc_read_mux.sv
module xbc_read_mux #(
  parameter int unsigned BYTES = 3,
  parameter int unsigned IDX_W = 4,
  parameter logic [BYTES*IDX_W-1:0] IDX_MAP = {4'hE, 4'h1, 4'h0}
) (
  input  logic [BYTES*8-1:0] count,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [7:0]         rd_data
);
  always_comb begin
    rd_data = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_idx == IDX_MAP[b*IDX_W +: IDX_W]) rd_data = count[b*8 +: 8];
    end
  end
endmodule

// File: rtl/xbc_status_pack.sv
module xbc_status_pack
  import xbc_pkg::*;
(
  input  logic       zero,
  input  logic       done,
  input  logic [2:0] phase,
  input  logic       parity_err,
  input  logic       gross_err,
  output logic [7:0] status
);
  always_comb begin
    status           = '0;
    status[2:0]      = phase;
    status[ST_DONE]  = done;
    status[ST_ZERO]  = zero;
    status[ST_PAR]   = parity_err;
    status[ST_GROSS] = gross_err;
  end
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xbc_pkg::*;
#(
  parameter int unsigned BYTES = 3,
  parameter logic [BYTES*IDX_W-1:0] IDX_MAP = {4'hE, 4'h1, 4'h0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             byte_stb,
  input  logic [2:0]       bus_phase,
  input  logic             parity_err,
  input  logic             gross_err,
  output logic [7:0]       status,
  output logic             cnt_zero,
  output logic             xfer_done
);
  localparam int unsigned CNT_W = BYTES * BYTE_W;

  logic [CNT_W-1:0] stage;
  logic [CNT_W-1:0] count_q;
  logic             load;
  logic             unused_cmd_bits;

  assign load            = cmd_valid && cmd_byte[DMA_BIT];
  assign unused_cmd_bits = ^cmd_byte[6:0];

  xbc_stage_regs #(.BYTES(BYTES), .IDX_W(IDX_W), .IDX_MAP(IDX_MAP)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .stage(stage)
  );

  xbc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(stage),
    .dec_stb(byte_stb), .count(count_q), .done(xfer_done)
  );

  xbc_read_mux #(.BYTES(BYTES), .IDX_W(IDX_W), .IDX_MAP(IDX_MAP)) u_rd (
    .count(count_q), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign cnt_zero = (count_q == '0);

  xbc_status_pack u_stat (
    .zero(cnt_zero), .done(xfer_done), .phase(bus_phase),
    .parity_err(parity_err), .gross_err(gross_err), .status(status)
  );
endmodule

// File: rtl/xfer_byte_counter_chk.sv
module xfer_byte_counter_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             byte_stb,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_zero,
  input logic             xfer_done,
  input logic [7:0]       status
);
  logic ld;
  assign ld = cmd_valid && cmd_byte[7];

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && byte_stb && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt == '0) |=> (cnt == '0));

  a_r3_ignore_plain_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_byte[7] && !byte_stb) |=> ($stable(cnt) && $stable(xfer_done)));

  a_r2_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld && !byte_stb) |=> $stable(cnt));

  a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && byte_stb && cnt == CNT_W'(1)) |=> xfer_done);

  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ld) |=> xfer_done);

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero == (cnt == '0)) && (status[4] == cnt_zero) && (status[3] == xfer_done));
endmodule

bind xfer_byte_counter xfer_byte_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .byte_stb(byte_stb), .cnt(count_q),
  .cnt_zero(cnt_zero), .xfer_done(xfer_done), .status(status)
);

// File: tb/test_xfer_byte_counter.sv
module test_xfer_byte_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  logic [3:0] rd_idx;
  logic [7:0] rd_data;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       byte_stb;
  logic [2:0] bus_phase;
  logic       parity_err;
  logic       gross_err;
  logic [7:0] status;
  logic       cnt_zero;
  logic       xfer_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_stage;
  int m_cnt;
  bit m_done;

  always #4 clk = ~clk;

  xfer_byte_counter i_xfer_byte_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .byte_stb(byte_stb), .bus_phase(bus_phase), .parity_err(parity_err),
    .gross_err(gross_err), .status(status), .cnt_zero(cnt_zero), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage <= 0; m_cnt <= 0; m_done <= 0;
    end else begin
      if (cmd_valid && cmd_byte[7]) begin
        m_cnt  <= m_stage;
        m_done <= (m_stage == 0);
      end else if (byte_stb && m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) m_done <= 1;
      end
      if (wr_en) begin
        case (wr_idx)
          4'h0: m_stage <= (m_stage & 32'hFFFF00) | int'(wr_data);
          4'h1: m_stage <= (m_stage & 32'hFF00FF) | (int'(wr_data) << 8);
          4'hE: m_stage <= (m_stage & 32'h00FFFF) | (int'(wr_data) << 16);
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(input logic [3:0] idx);
    case (idx)
      4'h0: return m_cnt & 255;
      4'h1: return (m_cnt >> 8) & 255;
      4'hE: return (m_cnt >> 16) & 255;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_status();
    return (int'(gross_err) << 6) | (int'(parity_err) << 5) |
           (int'(m_cnt == 0) << 4) | (int'(m_done) << 3) | int'(bus_phase);
  endfunction

  // per-cycle comparison, mid-cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk(int'(rd_data) == exp_rd(rd_idx), "R6 live count read", rd_data, exp_rd(rd_idx));
      chk(cnt_zero == (m_cnt == 0), "R7 zero flag", cnt_zero, m_cnt == 0);
      chk(xfer_done == m_done, "R8 done flag", xfer_done, m_done);
      chk(int'(status) == exp_status(), "R9 status byte", status, exp_status());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_valid = 1; cmd_byte = b; cyc(); cmd_valid = 0; cmd_byte = 0;
  endtask

  task automatic strobe(input int n);
    byte_stb = 1; repeat (n) cyc(); byte_stb = 0;
  endtask

  task automatic rd_chk(input logic [3:0] idx, input int exp, input string req);
    rd_idx = idx; #1;
    chk(int'(rd_data) == exp, req, rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0;
    cmd_valid = 0; cmd_byte = 0; byte_stb = 0; bus_phase = 0;
    parity_err = 0; gross_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    rd_chk(4'h0, 0, "R1 low byte");
    rd_chk(4'h1, 0, "R1 mid byte");
    rd_chk(4'hE, 0, "R1 high byte");
    chk(cnt_zero == 1 && xfer_done == 0, "R1 flags", {cnt_zero, xfer_done}, 2'b10);
    chk(status == 8'h10, "R1 status", status, 8'h10);

    // R2 staging write leaves count alone
    wr(4'h0, 8'd3); wr(4'h1, 8'd0); wr(4'hE, 8'd0);
    rd_chk(4'h0, 0, "R2 write no count change");

    // R3 plain command ignored, DMA command loads
    cmd(8'h10);
    rd_chk(4'h0, 0, "R3 non-DMA command ignored");
    chk(cnt_zero == 1, "R3 zero after non-DMA", cnt_zero, 1);
    cmd(8'h90);
    rd_chk(4'h0, 3, "R3 DMA command loads");
    chk(cnt_zero == 0 && xfer_done == 0, "R3 flags after load", {cnt_zero, xfer_done}, 2'b00);

    // R4 decrement, R8 done on last byte
    strobe(2);
    rd_chk(4'h0, 1, "R4 decrement by one");
    chk(xfer_done == 0, "R8 not done early", xfer_done, 0);
    strobe(1);
    rd_chk(4'h0, 0, "R4 reach zero");
    chk((status & 8'h18) == 8'h18, "R8 done and zero in status", status & 8'h18, 8'h18);

    // R5 no wrap
    strobe(3);
    rd_chk(4'h0, 0, "R5 no wrap low");
    rd_chk(4'hE, 0, "R5 no wrap high");
    chk(xfer_done == 1, "R8 done holds", xfer_done, 1);

    // R6 byte positions
    wr(4'h0, 8'h56); wr(4'h1, 8'h34); wr(4'hE, 8'h12);
    cmd(8'h80);
    rd_chk(4'h0, 8'h56, "R6 low byte");
    rd_chk(4'h1, 8'h34, "R6 mid byte");
    rd_chk(4'hE, 8'h12, "R6 high byte");
    rd_chk(4'h5, 0, "R6 other index");
    chk(xfer_done == 0, "R8 cleared by nonzero load", xfer_done, 0);

    // R10 load beats strobe
    strobe(4);
    byte_stb = 1; cmd(8'h80); byte_stb = 0;
    rd_chk(4'h0, 8'h56, "R10 load wins over strobe");

    // R11 load uses pre-write staging
    wr_en = 1; wr_idx = 4'h0; wr_data = 8'h77; cmd(8'h81); wr_en = 0;
    rd_chk(4'h0, 8'h56, "R11 load before same-cycle write");
    cmd(8'h80);
    rd_chk(4'h0, 8'h77, "R11 next load sees write");

    // R8 zero-length load
    wr(4'h0, 0); wr(4'h1, 0); wr(4'hE, 0);
    cmd(8'hC3);
    chk(cnt_zero == 1 && xfer_done == 1, "R8 zero load sets done", {cnt_zero, xfer_done}, 2'b11);
    strobe(1);
    rd_chk(4'h0, 0, "R5 strobe after zero load");

    // R9 phase and error bits
    for (int i = 0; i < 6; i++) begin
      logic [2:0] ph;
      ph = (i < 4) ? 3'(i) : 3'(i + 2);
      bus_phase = ph; parity_err = i[0]; gross_err = i[1]; #1;
      chk(status[2:0] == ph, "R9 phase field", status[2:0], ph);
      chk(status[5] == i[0] && status[6] == i[1] && status[7] == 0,
          "R9 error bits", status[7:5], {1'b0, i[1], i[0]});
    end
    cyc();

    // mixed traffic compared every cycle against the model
    for (int n = 0; n < 500; n++) begin
      int pick;
      pick = int'($urandom % 4);
      wr_en  = ($urandom % 6) == 0;
      wr_idx = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h1 : (pick == 2) ? 4'hE : 4'h5;
      wr_data = (pick == 0) ? 8'($urandom % 8) : ((($urandom % 4) == 0) ? 8'($urandom % 2) : 8'h0);
      cmd_valid = ($urandom % 10) == 0;
      cmd_byte  = 8'($urandom);
      byte_stb  = $urandom % 2;
      bus_phase = 3'($urandom);
      parity_err = $urandom % 2;
      gross_err  = $urandom % 2;
      pick = int'($urandom % 4);
      rd_idx = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h1 : (pick == 2) ? 4'hE : 4'h3;
      cyc();
    end
    wr_en = 0; cmd_valid = 0; byte_stb = 0;
    cyc();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule